// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Decoder with Refresh Row Counter

This block is the device-side control logic of an asynchronous dynamic RAM, rebuilt as a synchronous oversampling design. A fast system clock samples the row strobe, the two byte column strobes, write-enable, output-enable, the multiplexed address bus and the input data bus. The block then works out from the sampled edges what kind of memory cycle the host is running.

The two byte column strobes are merged into one internal column strobe. At the fall of the row strobe the block decides between a counter-driven refresh and a normal row activation. Within an activated row it tells early writes, late writes, reads and read-modify-write cycles apart from the order in which the strobes fall. It latches row and column addresses and writes into a small storage array with per-byte enables. It drives per-byte output enables and keeps a row counter for refresh cycles that supply no address. A debug port reports the last decoded cycle type together with the latched row and column, so each decode can be observed.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: The merged column strobe becomes active when the first byte strobe falls. The column address is latched only at that moment, so a second byte strobe falling later with a different address leaves `dbg_col` unchanged.
- R2: The merged column strobe stays active until both byte strobes are high. Raising one byte strobe and lowering it again while the other stays low starts no new column access: `dbg_col` and the read data are kept, and only that byte's output enable drops while its strobe is high.
- R3: If any column strobe is low when the row strobe falls, the cycle is a counter refresh. `dbg_kind` becomes 6, `dbg_row` takes the refresh counter value, the address bus is ignored, and `dout_en` stays 0.
- R4: The refresh counter is 9 bits wide and resets to 0. It advances by one after each counter refresh and wraps from 511 to 0.
- R5: A row strobe fall with both column strobes high latches the address as the row and sets `dbg_kind` to 5 (row-only refresh), with `dout_en` at 0.
- R6: If write-enable is low when the merged column strobe falls, the cycle is an early write. `dbg_kind` becomes 2, `din` is stored only into the bytes whose strobe is low (bit 0 of a mask = lower byte, `din[7:0]`, lower strobe), and `dout_en` stays 0.
- R7: A column fall with write-enable and output-enable both high sets `dbg_kind` to 7 (command pending). A read starts at the later of the column fall and the output-enable fall while write-enable is high, and then `dbg_kind` becomes 1. `dout_en[0]` is driven only while the lower strobe is low and `dout_en[1]` only while the upper strobe is low, and `dout` carries the stored word.
- R8: If write-enable falls after the column strobe, with output-enable high and no read yet, the cycle is a late write. `dbg_kind` becomes 3, `din` is stored into the strobed bytes, and `dout_en` stays 0.
- R9: If write-enable falls after a read in the same column access, the cycle is a read-modify-write. The outputs first show the old data, then `dbg_kind` becomes 4 and the new data is stored.
- R10: Raising output-enable or lowering write-enable during a read sets `dout_en` to 0.
- R11: If the row strobe rises and falls again while a read's column strobes stay low (hidden refresh), the output data and its enables are held, and the cycle is counted as a counter refresh.
- R12: After reset `dbg_kind` is 0 and `dout_en` is 0.
- R13: With default parameters the storage word is selected by row bits [2:0] and column bits [2:0] (index = {row[2:0], col[2:0]}), 64 words of 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write-enable, active low |
| oe_n | input | 1 | Output-enable, active low |
| addr | input | ADDR_W (9) | Multiplexed row/column address |
| din | input | DATA_W (16) | Write data |
| dout | output | DATA_W (16) | Read data |
| dout_en | output | 2 | Per-byte output drive enable (bit 0 lower) |
| dbg_kind | output | 3 | Last decoded cycle type |
| dbg_row | output | ADDR_W (9) | Latched row |
| dbg_col | output | ADDR_W (9) | Latched column |

## Verification
The bench builds the block with its defaults: a 9-bit address, so the whole refresh counter range including the 511-to-0 wrap is exercised by a run of counter refresh cycles, and a 3+3 bit array index, so all 64 words are written at start and then compared against a bench memory model. Random row and column values across the full 9-bit bus fold onto that small array, so writes to aliasing addresses also meet later reads. The directed cases put the strobe edge orderings that choose early against late write, byte strobe overlap and hidden refresh within reach.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_LWR   = 3'd3,
    K_RMW   = 3'd4,
    K_RONLY = 3'd5,
    K_CBR   = 3'd6,
    K_PEND  = 3'd7
  } cyc_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ROW  = 2'd1,
    S_CBR  = 2'd2
  } row_state_e;

  typedef struct packed {
    logic ras_n;
    logic lcas_n;
    logic ucas_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

endpackage

// File: rtl/pin_sampler.sv
module pin_sampler
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output strobe_t           cur,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_din,
  output logic              prv_ras_n,
  output logic              prv_lcas_n,
  output logic              prv_ucas_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= '1;
      cur_addr   <= '0;
      cur_din    <= '0;
      prv_ras_n  <= 1'b1;
      prv_lcas_n <= 1'b1;
      prv_ucas_n <= 1'b1;
    end else begin
      cur        <= '{ras_n: ras_n, lcas_n: lcas_n, ucas_n: ucas_n,
                      we_n: we_n, oe_n: oe_n};
      cur_addr   <= addr;
      cur_din    <= din;
      prv_ras_n  <= cur.ras_n;
      prv_lcas_n <= cur.lcas_n;
      prv_ucas_n <= cur.ucas_n;
    end
  end

endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
  parameter int REF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [REF_W-1:0] cnt
);

  logic [REF_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam int DEPTH  = 1 << IDX_W;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && be[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[idx];
  end

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int ARR_ROW_W = 3,
  parameter int ARR_COL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        dout_en,
  output logic [2:0]        dbg_kind,
  output logic [ADDR_W-1:0] dbg_row,
  output logic [ADDR_W-1:0] dbg_col
);

  localparam int REF_W = ADDR_W;
  localparam int IDX_W = ARR_ROW_W + ARR_COL_W;

  strobe_t           cur;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_din;
  logic              prv_ras_n, prv_lcas_n, prv_ucas_n;

  pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n),
    .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din),
    .cur(cur), .cur_addr(cur_addr), .cur_din(cur_din),
    .prv_ras_n(prv_ras_n), .prv_lcas_n(prv_lcas_n), .prv_ucas_n(prv_ucas_n)
  );

  // merged column strobe: active while any byte strobe is low
  logic cas_act, cas_was, cas_fall, ras_fall;
  assign cas_act  = ~cur.lcas_n | ~cur.ucas_n;
  assign cas_was  = ~prv_lcas_n | ~prv_ucas_n;
  assign cas_fall = cas_act & ~cas_was;
  assign ras_fall = ~cur.ras_n & prv_ras_n;

  logic             ref_inc;
  logic [REF_W-1:0] ref_cnt;

  refresh_ctr #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .inc(ref_inc), .cnt(ref_cnt)
  );

  row_state_e        state_q, state_d;
  cyc_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d;
  logic              rd_q, rd_d, wr_q, wr_d;
  logic [DATA_W-1:0] dout_q, dout_d;

  logic              col_acc, new_col, eff_rd, eff_wr, wr_go, rd_go;
  logic [ADDR_W-1:0] col_use;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rdata;

  always_comb begin
    ref_inc = ras_fall & cas_act;
    col_acc = (state_q == S_ROW) & ~cur.ras_n & cas_act;
    new_col = col_acc & cas_fall;
    eff_rd  = new_col ? 1'b0 : rd_q;
    eff_wr  = new_col ? 1'b0 : wr_q;
    wr_go   = col_acc & ~cur.we_n & ~eff_wr;
    rd_go   = col_acc & cur.we_n & ~cur.oe_n & ~eff_rd & ~eff_wr;
    col_use = new_col ? cur_addr : col_q;
    col_d   = col_use;
    idx     = {row_q[ARR_ROW_W-1:0], col_use[ARR_COL_W-1:0]};

    state_d = state_q;
    if (cur.ras_n)     state_d = S_IDLE;
    else if (ras_fall) state_d = cas_act ? S_CBR : S_ROW;

    row_d = row_q;
    if (ras_fall) row_d = cas_act ? ref_cnt : cur_addr;

    kind_d = kind_q;
    if (ras_fall)     kind_d = cas_act ? K_CBR : K_RONLY;
    else if (wr_go)   kind_d = new_col ? K_EWR : (eff_rd ? K_RMW : K_LWR);
    else if (rd_go)   kind_d = K_READ;
    else if (new_col) kind_d = K_PEND;

    rd_d = rd_q;
    if (!cas_act)     rd_d = 1'b0;
    else if (rd_go)   rd_d = 1'b1;
    else if (new_col) rd_d = 1'b0;

    wr_d = wr_q;
    if (!cas_act)     wr_d = 1'b0;
    else if (wr_go)   wr_d = 1'b1;
    else if (new_col) wr_d = 1'b0;

    dout_d = dout_q;
    if (rd_go) dout_d = rdata;
  end

  word_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_go), .be({~cur.ucas_n, ~cur.lcas_n}),
    .idx(idx), .wdata(cur_din), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      row_q   <= '0;
      col_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      row_q   <= row_d;
      col_q   <= col_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      dout_q  <= dout_d;
    end
  end

  assign dout     = dout_q;
  assign dout_en  = {2{rd_q & ~cur.oe_n & cur.we_n}} & {~cur.ucas_n, ~cur.lcas_n};
  assign dbg_kind = kind_q;
  assign dbg_row  = row_q;
  assign dbg_col  = col_q;

endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
module dram_strobe_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_fall,
  input logic              cas_act,
  input logic              new_col,
  input logic [ADDR_W-1:0] ref_cnt,
  input logic [ADDR_W-1:0] dbg_row,
  input logic [ADDR_W-1:0] dbg_col,
  input logic [2:0]        dbg_kind,
  input logic [1:0]        dout_en,
  input logic              lcas_s,
  input logic              ucas_s,
  input logic              we_s
);

  p_cbr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_act) |=> ref_cnt == ADDR_W'($past(ref_cnt) + 1'b1));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_fall && cas_act) |=> $stable(ref_cnt));

  p_cbr_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_act) |=> dbg_row == $past(ref_cnt));

  p_col_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !new_col |=> $stable(dbg_col));

  p_low_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en[0] |-> !lcas_s);

  p_high_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en[1] |-> !ucas_s);

  p_we_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_s |-> dout_en == 2'b00);

  p_early_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_kind == 3'd2 |-> dout_en == 2'b00);

endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .cas_act(cas_act),
  .new_col(new_col), .ref_cnt(ref_cnt), .dbg_row(dbg_row), .dbg_col(dbg_col),
  .dbg_kind(dbg_kind), .dout_en(dout_en), .lcas_s(cur.lcas_n),
  .ucas_s(cur.ucas_n), .we_s(cur.we_n)
);

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic [2:0]  dbg_kind;
  logic [8:0]  dbg_row, dbg_col;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [15:0] mdl [64];
  logic [8:0]  refcnt = '0;

  always #10 clk = ~clk;

  dram_strobe_ctrl i_dram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .dbg_kind(dbg_kind), .dbg_row(dbg_row), .dbg_col(dbg_col)
  );

  function automatic int idx(input logic [8:0] r, input logic [8:0] c);
    return int'({r[2:0], c[2:0]});
  endfunction

  function automatic logic [15:0] lmask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stp();
    repeat (3) @(negedge clk);
  endtask

  task automatic idle();
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    stp();
  endtask

  task automatic put(input logic [8:0] r, input logic [8:0] c, input logic [1:0] m, input logic [15:0] d);
    mdl[idx(r, c)] = (mdl[idx(r, c)] & ~lmask(m)) | (d & lmask(m));
  endtask

  task automatic early_wr(input logic [8:0] r, input logic [8:0] c, input logic [1:0] m, input logic [15:0] d);
    addr = r; ras_n = 1'b0; stp();
    addr = c; din = d; we_n = 1'b0; lcas_n = ~m[0]; ucas_n = ~m[1]; stp();
    chk(dbg_kind == 3'd2, "R6 kind", dbg_kind, 2);
    chk(dbg_row == r && dbg_col == c, "R6 row/col", {dbg_row, dbg_col}, {r, c});
    chk(dout_en == 2'b00, "R6 no drive", dout_en, 0);
    put(r, c, m, d);
    idle();
  endtask

  task automatic rd(input logic [8:0] r, input logic [8:0] c, input logic [1:0] m);
    logic [15:0] e;
    e = mdl[idx(r, c)] & lmask(m);
    addr = r; ras_n = 1'b0; stp();
    addr = c; lcas_n = ~m[0]; ucas_n = ~m[1]; stp();
    chk(dbg_kind == 3'd7, "R7 pending", dbg_kind, 7);
    chk(dout_en == 2'b00, "R7 no drive before oe", dout_en, 0);
    oe_n = 1'b0; stp();
    chk(dbg_kind == 3'd1, "R7 kind", dbg_kind, 1);
    chk(dout_en == m, "R7 lanes", dout_en, m);
    chk((dout & lmask(m)) == e, "R7 data", dout & lmask(m), e);
    oe_n = 1'b1; stp();
    chk(dout_en == 2'b00, "R10 oe high", dout_en, 0);
    idle();
  endtask

  task automatic late_wr(input logic [8:0] r, input logic [8:0] c, input logic [1:0] m, input logic [15:0] d);
    addr = r; ras_n = 1'b0; stp();
    addr = c; lcas_n = ~m[0]; ucas_n = ~m[1]; stp();
    din = d; we_n = 1'b0; stp();
    chk(dbg_kind == 3'd3, "R8 kind", dbg_kind, 3);
    chk(dout_en == 2'b00, "R8 no drive", dout_en, 0);
    put(r, c, m, d);
    idle();
  endtask

  task automatic rmw(input logic [8:0] r, input logic [8:0] c, input logic [1:0] m, input logic [15:0] d);
    logic [15:0] e;
    e = mdl[idx(r, c)] & lmask(m);
    addr = r; ras_n = 1'b0; stp();
    addr = c; lcas_n = ~m[0]; ucas_n = ~m[1]; oe_n = 1'b0; stp();
    chk((dout & lmask(m)) == e && dout_en == m, "R9 old data", dout & lmask(m), e);
    oe_n = 1'b1; din = d; we_n = 1'b0; stp();
    chk(dbg_kind == 3'd4, "R9 kind", dbg_kind, 4);
    chk(dout_en == 2'b00, "R10 we low", dout_en, 0);
    put(r, c, m, d);
    idle();
  endtask

  task automatic ronly(input logic [8:0] r);
    addr = r; ras_n = 1'b0; stp();
    chk(dbg_kind == 3'd5 && dbg_row == r, "R5 row-only", {dbg_kind, dbg_row}, {3'd5, r});
    chk(dout_en == 2'b00, "R5 no drive", dout_en, 0);
    idle();
  endtask

  task automatic cbr(input logic [1:0] m);
    lcas_n = ~m[0]; ucas_n = ~m[1]; stp();
    addr = 9'($urandom); ras_n = 1'b0; stp();
    chk(dbg_kind == 3'd6, "R3 kind", dbg_kind, 6);
    chk(dbg_row == refcnt, "R3 R4 counter row", dbg_row, refcnt);
    chk(dout_en == 2'b00, "R3 no drive", dout_en, 0);
    refcnt = refcnt + 1'b1;
    idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] hv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stp();
    chk(dbg_kind == 3'd0, "R12 reset kind", dbg_kind, 0);
    chk(dout_en == 2'b00, "R12 reset drive", dout_en, 0);

    // R13: fill all 64 words through aliasing-free indices
    for (int i = 0; i < 64; i++)
      early_wr(9'({$urandom % 64, 3'(i >> 3)}), 9'({$urandom % 64, 3'(i)}), 2'b11, 16'($urandom));

    // R1: second byte strobe does not relatch the column
    addr = 9'h012; ras_n = 1'b0; stp();
    addr = 9'h005; din = 16'hA55A; we_n = 1'b0; lcas_n = 1'b0; stp();
    addr = 9'h1F3; din = 16'h3CC3; ucas_n = 1'b0; stp();
    chk(dbg_col == 9'h005, "R1 first fall column", dbg_col, 9'h005);
    put(9'h012, 9'h005, 2'b01, 16'hA55A);
    idle();
    rd(9'h012, 9'h005, 2'b11);

    // R2: merged strobe held by the other byte
    addr = 9'h0A1; ras_n = 1'b0; stp();
    addr = 9'h044; lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0; stp();
    hv = dout;
    lcas_n = 1'b1; stp();
    chk(dout_en == 2'b10, "R2 lower released", dout_en, 2);
    addr = 9'h077; lcas_n = 1'b0; stp();
    chk(dbg_col == 9'h044 && dbg_kind == 3'd1, "R2 no new access", dbg_col, 9'h044);
    chk(dout_en == 2'b11 && dout == hv, "R2 data kept", dout, hv);
    idle();

    // R11: hidden refresh holds the read output
    addr = 9'h0C3; ras_n = 1'b0; stp();
    addr = 9'h002; lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0; stp();
    hv = dout;
    ras_n = 1'b1; stp();
    chk(dout_en == 2'b11, "R11 held after row rise", dout_en, 3);
    ras_n = 1'b0; stp();
    chk(dbg_kind == 3'd6 && dbg_row == refcnt, "R11 counted refresh", dbg_row, refcnt);
    chk(dout_en == 2'b11 && dout == hv, "R11 data held", dout, hv);
    refcnt = refcnt + 1'b1;
    idle();

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [8:0]  r, c;
      logic [1:0]  m;
      logic [15:0] d;
      r = 9'($urandom); c = 9'($urandom); m = 2'($urandom % 3 + 1); d = 16'($urandom);
      case ($urandom % 6)
        0: early_wr(r, c, m, d);
        1: rd(r, c, m);
        2: late_wr(r, c, m, d);
        3: rmw(r, c, m, d);
        4: ronly(r);
        default: cbr(m);
      endcase
    end

    // R4: run the counter through its wrap
    for (int k = 0; k < 520; k++) cbr(2'($urandom % 3 + 1));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule